// File: doc/BRIEF.md
# Interleaved Angle Sensor Poll Sequencer

This block is the control sequencer for a magnetic angle sensor on a serial link whose replies are pipelined: the word returned in a frame always answers the command sent in the frame before it. To read the rotor angle as often as possible and still refresh the slower status registers, the sequencer alternates angle reads with one auxiliary read. The auxiliary register rotates through magnitude, gain control, diagnostics and error flags. A frame that asks for an auxiliary register brings back an angle. The angle read chained right behind it brings back that auxiliary register.

The block does no serial shifting and no checksum arithmetic. It hands a 16-bit command word to a frame engine with a one-cycle strobe. It takes back a 16-bit reply together with a checksum-good flag, and decodes the reply into angle, magnitude, gain and flag outputs. Each output field has its own one-cycle valid pulse.

A reply that fails its checksum, or that carries the sensor's error flag, bumps a saturating error counter. The sequencer then enters a recovery path: it reads the error-flag register, drops the reply that comes back with that request, and decodes the reply after it as the error flags. It then resumes the normal rotation at magnitude.

Top module: `angle_poll_seq`

## Requirements
- R1: After reset, no command is issued, every valid output is low, every decoded field is zero and the error count is zero.
- R2: Every command is a read: bit 15 is 0, bit 14 is 1, and bits 13:0 hold the register address. The addresses are angle 0x3FFF, magnitude 0x3FFD, gain 0x3FF9, diagnostics 0x3FF5 and error flags 0x0001.
- R3: From reset with error-free replies, commands follow a fixed order: magnitude, angle, gain, angle, diagnostics, angle, error flags, angle, and then back to magnitude. Each auxiliary command is started by a tick. Each angle command after an auxiliary reply is issued without a tick, on the first cycle after the reply in which the engine is idle.
- R4: A good reply to an auxiliary command is taken as the angle. Its bits 13:0 appear on the angle output one cycle after the reply strobe, with a one-cycle angle valid pulse.
- R5: A good reply to a chained angle command is decoded as the auxiliary register requested before it. Magnitude is bits 13:0 and gain is bits 7:0. For diagnostics, bit 10 is the hall fault, bit 2 the CORDIC overflow, bit 3 field too low and bit 4 field too high. For error flags, bit 7 is the watchdog test, bit 6 the CRC error and bit 1 half magnitude. Each field group has its own valid pulse one cycle after the reply.
- R6: A reply with the checksum flag low, or with bit 14 set, updates no field and raises no valid pulse. The error count rises by exactly one and saturates at its maximum, and the sequencer enters recovery.
- R7: In recovery, the next tick issues an error-flag read (0x4001). The reply to that read is discarded. An angle command follows it without a tick, and the reply to that angle command is decoded as error flags. The next tick then issues a magnitude read.
- R8: Reply bit 15 (warning) has no effect: it does not count as an error and does not appear in any decoded field.
- R9: A command is issued only while the engine-busy input is low and no reply is outstanding. A tick at any other time is ignored.
- R10: Every valid output is high for one cycle at a time, and each decoded field holds its value between its valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Poll request; starts a tick-driven frame when allowed |
| engBusy | input | 1 | Frame engine is busy with a frame |
| cmdValid | output | 1 | One-cycle strobe: start a frame with cmdWord |
| cmdWord | output | 16 | Command word for the frame engine |
| rspValid | input | 1 | One-cycle strobe: a reply has arrived |
| rspWord | input | 16 | Reply word |
| rspCrcOk | input | 1 | Reply checksum matched |
| angle | output | 14 | Decoded angle |
| angleValid | output | 1 | Angle updated |
| magnitude | output | 14 | Decoded field magnitude |
| magValid | output | 1 | Magnitude updated |
| gain | output | 8 | Decoded gain-control value |
| gainValid | output | 1 | Gain updated |
| hallFault | output | 1 | Diagnostics: hall fault |
| cordicOvf | output | 1 | Diagnostics: CORDIC overflow |
| fieldLow | output | 1 | Diagnostics: field too low |
| fieldHigh | output | 1 | Diagnostics: field too high |
| diagValid | output | 1 | Diagnostic flags updated |
| wdtFlag | output | 1 | Error flags: watchdog test |
| crcFlag | output | 1 | Error flags: CRC error |
| halfMag | output | 1 | Error flags: half magnitude |
| errFlagsValid | output | 1 | Error flags updated |
| errCount | output | ERR_W | Saturating count of failed replies |

## Verification
The bench models a pipelined sensor and a frame engine with a fixed latency. It drives ticks that often land while a frame is in flight. A sequencer that ignored the busy or outstanding state would then issue overlapping commands. The bench injects checksum failures and error-flag replies at different points in the rotation, including one burst long enough to drive the counter into saturation. A design that decoded the discarded recovery reply would raise a false error-flag pulse. One that lost the one-frame lag would put magnitude values on the angle output, and one that wrapped the counter would show a small count after the burst. Magnitude replies carry the warning bit, so a design that treated warnings as errors would enter recovery where the model does not.

// File: rtl/aps_pkg.sv
package aps_pkg;

  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 14;
  localparam int ANGLE_W = 14;
  localparam int GAIN_W  = 8;

  localparam int READ_BIT = 14;
  localparam int ERR_BIT  = 14;

  localparam logic [ADDR_W-1:0] ADDR_ERRFL = 14'h0001;
  localparam logic [ADDR_W-1:0] ADDR_DIAG  = 14'h3FF5;
  localparam logic [ADDR_W-1:0] ADDR_MAG   = 14'h3FFD;
  localparam logic [ADDR_W-1:0] ADDR_GAIN  = 14'h3FF9;
  localparam logic [ADDR_W-1:0] ADDR_ANGLE = 14'h3FFF;

  localparam int DIAG_HALL_POS = 10;
  localparam int DIAG_OVF_POS  = 2;
  localparam int DIAG_LOW_POS  = 3;
  localparam int DIAG_HIGH_POS = 4;
  localparam int EFL_WDT_POS   = 7;
  localparam int EFL_CRC_POS   = 6;
  localparam int EFL_HALF_POS  = 1;

  typedef enum logic [2:0] {
    SEL_ANGLE, SEL_MAG, SEL_GAIN, SEL_DIAG, SEL_ERRFL
  } regSel_e;

  // Even states send an auxiliary request, odd ones the chained angle read.
  typedef enum logic [3:0] {
    ST_ASK_MAG   = 4'd0,
    ST_GET_MAG   = 4'd1,
    ST_ASK_GAIN  = 4'd2,
    ST_GET_GAIN  = 4'd3,
    ST_ASK_DIAG  = 4'd4,
    ST_GET_DIAG  = 4'd5,
    ST_ASK_ERRFL = 4'd6,
    ST_GET_ERRFL = 4'd7,
    ST_RECOVER   = 4'd8
  } seqState_e;

  typedef struct packed {
    logic    issue;
    regSel_e sel;
    logic    ldAngle;
    logic    ldMag;
    logic    ldGain;
    logic    ldDiag;
    logic    ldErrFl;
    logic    bumpErr;
  } ctrlStrobes_t;

  function automatic logic [ADDR_W-1:0] regAddr(input regSel_e s);
    case (s)
      SEL_MAG:   regAddr = ADDR_MAG;
      SEL_GAIN:  regAddr = ADDR_GAIN;
      SEL_DIAG:  regAddr = ADDR_DIAG;
      SEL_ERRFL: regAddr = ADDR_ERRFL;
      default:   regAddr = ADDR_ANGLE;
    endcase
  endfunction

endpackage

// File: rtl/aps_ctrl.sv
module aps_ctrl
  import aps_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         engBusy,
  input  logic         rspValid,
  input  logic         rspCrcOk,
  input  logic         rspErrFlag,
  output ctrlStrobes_t strb
);

  seqState_e state, stateNext;
  logic      waitRsp;
  logic      chained;
  logic      accept;
  logic      goodRsp;

  always_comb begin
    case (state)
      ST_GET_MAG, ST_GET_GAIN, ST_GET_DIAG, ST_GET_ERRFL: chained = 1'b1;
      default:                                            chained = 1'b0;
    endcase
  end

  assign accept  = rspValid && waitRsp;
  assign goodRsp = rspCrcOk && !rspErrFlag;

  always_comb begin
    strb       = '0;
    strb.sel   = SEL_ERRFL;
    stateNext  = state;

    strb.issue = !waitRsp && !engBusy && (chained || tick);
    case (state)
      ST_ASK_MAG:  strb.sel = SEL_MAG;
      ST_ASK_GAIN: strb.sel = SEL_GAIN;
      ST_ASK_DIAG: strb.sel = SEL_DIAG;
      ST_GET_MAG, ST_GET_GAIN, ST_GET_DIAG, ST_GET_ERRFL: strb.sel = SEL_ANGLE;
      default:     strb.sel = SEL_ERRFL;
    endcase

    if (accept) begin
      if (!goodRsp) begin
        strb.bumpErr = 1'b1;
        stateNext    = ST_RECOVER;
      end else begin
        case (state)
          ST_ASK_MAG:   begin strb.ldAngle = 1'b1; stateNext = ST_GET_MAG;   end
          ST_GET_MAG:   begin strb.ldMag   = 1'b1; stateNext = ST_ASK_GAIN;  end
          ST_ASK_GAIN:  begin strb.ldAngle = 1'b1; stateNext = ST_GET_GAIN;  end
          ST_GET_GAIN:  begin strb.ldGain  = 1'b1; stateNext = ST_ASK_DIAG;  end
          ST_ASK_DIAG:  begin strb.ldAngle = 1'b1; stateNext = ST_GET_DIAG;  end
          ST_GET_DIAG:  begin strb.ldDiag  = 1'b1; stateNext = ST_ASK_ERRFL; end
          ST_ASK_ERRFL: begin strb.ldAngle = 1'b1; stateNext = ST_GET_ERRFL; end
          ST_GET_ERRFL: begin strb.ldErrFl = 1'b1; stateNext = ST_ASK_MAG;   end
          ST_RECOVER:   stateNext = ST_GET_ERRFL;
          default:      stateNext = ST_ASK_MAG;
        endcase
      end
    end else begin
      case (state)
        ST_ASK_MAG, ST_GET_MAG, ST_ASK_GAIN, ST_GET_GAIN, ST_ASK_DIAG,
        ST_GET_DIAG, ST_ASK_ERRFL, ST_GET_ERRFL, ST_RECOVER: stateNext = state;
        default: stateNext = ST_ASK_MAG;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_ASK_MAG;
      waitRsp <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.issue)  waitRsp <= 1'b1;
      else if (accept) waitRsp <= 1'b0;
    end
  end

endmodule

// File: rtl/aps_dp.sv
module aps_dp
  import aps_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strb,
  input  logic [ADDR_W-1:0]   rspData,
  output logic                cmdValid,
  output logic [WORD_W-1:0]   cmdWord,
  output logic [ANGLE_W-1:0]  angle,
  output logic                angleValid,
  output logic [ANGLE_W-1:0]  magnitude,
  output logic                magValid,
  output logic [GAIN_W-1:0]   gain,
  output logic                gainValid,
  output logic [3:0]          diagBits,
  output logic                diagValid,
  output logic [2:0]          errFlBits,
  output logic                errFlagsValid,
  output logic [ERR_W-1:0]    errCount
);

  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid      <= 1'b0;
      cmdWord       <= '0;
      angle         <= '0;
      angleValid    <= 1'b0;
      magnitude     <= '0;
      magValid      <= 1'b0;
      gain          <= '0;
      gainValid     <= 1'b0;
      diagBits      <= '0;
      diagValid     <= 1'b0;
      errFlBits     <= '0;
      errFlagsValid <= 1'b0;
      errCount      <= '0;
    end else begin
      cmdValid      <= strb.issue;
      angleValid    <= strb.ldAngle;
      magValid      <= strb.ldMag;
      gainValid     <= strb.ldGain;
      diagValid     <= strb.ldDiag;
      errFlagsValid <= strb.ldErrFl;

      if (strb.issue) cmdWord <= {1'b0, 1'b1, regAddr(strb.sel)};
      if (strb.ldAngle) angle     <= rspData[ANGLE_W-1:0];
      if (strb.ldMag)   magnitude <= rspData[ANGLE_W-1:0];
      if (strb.ldGain)  gain      <= rspData[GAIN_W-1:0];
      if (strb.ldDiag)
        diagBits <= {rspData[DIAG_HIGH_POS], rspData[DIAG_LOW_POS],
                     rspData[DIAG_OVF_POS], rspData[DIAG_HALL_POS]};
      if (strb.ldErrFl)
        errFlBits <= {rspData[EFL_HALF_POS], rspData[EFL_CRC_POS], rspData[EFL_WDT_POS]};
      if (strb.bumpErr && errCount != ERR_MAX) errCount <= errCount + 1'b1;
    end
  end

endmodule

// File: rtl/angle_poll_seq.sv
module angle_poll_seq
  import aps_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             engBusy,
  output logic             cmdValid,
  output logic [15:0]      cmdWord,
  input  logic             rspValid,
  input  logic [15:0]      rspWord,
  input  logic             rspCrcOk,
  output logic [13:0]      angle,
  output logic             angleValid,
  output logic [13:0]      magnitude,
  output logic             magValid,
  output logic [7:0]       gain,
  output logic             gainValid,
  output logic             hallFault,
  output logic             cordicOvf,
  output logic             fieldLow,
  output logic             fieldHigh,
  output logic             diagValid,
  output logic             wdtFlag,
  output logic             crcFlag,
  output logic             halfMag,
  output logic             errFlagsValid,
  output logic [ERR_W-1:0] errCount
);

  ctrlStrobes_t strb;
  logic [3:0]   diagBits;
  logic [2:0]   errFlBits;

  aps_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .engBusy    (engBusy),
    .rspValid   (rspValid),
    .rspCrcOk   (rspCrcOk),
    .rspErrFlag (rspWord[ERR_BIT]),
    .strb       (strb)
  );

  aps_dp #(.ERR_W(ERR_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .rspData       (rspWord[ADDR_W-1:0]),
    .cmdValid      (cmdValid),
    .cmdWord       (cmdWord),
    .angle         (angle),
    .angleValid    (angleValid),
    .magnitude     (magnitude),
    .magValid      (magValid),
    .gain          (gain),
    .gainValid     (gainValid),
    .diagBits      (diagBits),
    .diagValid     (diagValid),
    .errFlBits     (errFlBits),
    .errFlagsValid (errFlagsValid),
    .errCount      (errCount)
  );

  assign hallFault = diagBits[0];
  assign cordicOvf = diagBits[1];
  assign fieldLow  = diagBits[2];
  assign fieldHigh = diagBits[3];
  assign wdtFlag   = errFlBits[0];
  assign crcFlag   = errFlBits[1];
  assign halfMag   = errFlBits[2];

endmodule

// File: rtl/aps_chk.sv
module aps_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             engBusy,
  input logic             cmdValid,
  input logic [15:0]      cmdWord,
  input logic             rspValid,
  input logic [15:0]      rspWord,
  input logic             rspCrcOk,
  input logic [13:0]      angle,
  input logic             angleValid,
  input logic             magValid,
  input logic             gainValid,
  input logic             diagValid,
  input logic             errFlagsValid,
  input logic [ERR_W-1:0] errCount
);

  // R9
  cmd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(!engBusy));

  // R2
  cmd_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdWord[15:14] == 2'b01));

  // R10
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R10
  one_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({angleValid, magValid, gainValid, diagValid, errFlagsValid}));

  // R10
  angle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !angleValid |-> $stable(angle));

  // R6
  field_good_chk: assert property (@(posedge clk) disable iff (!rstN)
    (angleValid || magValid || gainValid || diagValid || errFlagsValid)
      |-> $past(rspValid && rspCrcOk && !rspWord[14]));

  // R6
  err_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errCount != $past(errCount)) |-> (errCount == $past(errCount) + 1'b1));

  // R8
  warn_benign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCrcOk && !rspWord[14]) |=> (errCount == $past(errCount)));

endmodule

bind angle_poll_seq aps_chk #(.ERR_W(ERR_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .engBusy       (engBusy),
  .cmdValid      (cmdValid),
  .cmdWord       (cmdWord),
  .rspValid      (rspValid),
  .rspWord       (rspWord),
  .rspCrcOk      (rspCrcOk),
  .angle         (angle),
  .angleValid    (angleValid),
  .magValid      (magValid),
  .gainValid     (gainValid),
  .diagValid     (diagValid),
  .errFlagsValid (errFlagsValid),
  .errCount      (errCount)
);

// File: tb/tb_angle_poll_seq.sv
`timescale 1ns/1ps
module tb_angle_poll_seq;

  localparam int ERRW = 3;
  localparam int ECAP = 7;
  localparam int LAT  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, engBusy = 1'b0, rspValid = 1'b0, rspCrcOk = 1'b0;
  logic [15:0] rspWord = '0;
  logic cmdValid, angleValid, magValid, gainValid, diagValid, errFlagsValid;
  logic [15:0] cmdWord;
  logic [13:0] angle, magnitude;
  logic [7:0]  gain;
  logic hallFault, cordicOvf, fieldLow, fieldHigh, wdtFlag, crcFlag, halfMag;
  logic [ERRW-1:0] errCount;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  angle_poll_seq #(.ERR_W(ERRW)) dut (
    .clk(clk), .rstN(rstN), .tick(tick), .engBusy(engBusy),
    .cmdValid(cmdValid), .cmdWord(cmdWord),
    .rspValid(rspValid), .rspWord(rspWord), .rspCrcOk(rspCrcOk),
    .angle(angle), .angleValid(angleValid),
    .magnitude(magnitude), .magValid(magValid),
    .gain(gain), .gainValid(gainValid),
    .hallFault(hallFault), .cordicOvf(cordicOvf), .fieldLow(fieldLow),
    .fieldHigh(fieldHigh), .diagValid(diagValid),
    .wdtFlag(wdtFlag), .crcFlag(crcFlag), .halfMag(halfMag),
    .errFlagsValid(errFlagsValid), .errCount(errCount)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model state
  int  mState = 0;
  bit  mWait = 0;
  bit  eCmdV = 0, eAngV = 0, eMagV = 0, eGainV = 0, eDiagV = 0, eErrV = 0;
  int  eCmd = 0, eAng = 0, eMag = 0, eGain = 0, eDiag = 0, eErrFl = 0, eCnt = 0;

  function automatic int addrFor(input int s);
    case (s)
      0: return 'h3FFD;
      2: return 'h3FF9;
      4: return 'h3FF5;
      1, 3, 5, 7: return 'h3FFF;
      default: return 'h0001;
    endcase
  endfunction

  task automatic modelStep();
    int  s  = mState;
    bit  w  = mWait;
    int  d  = int'(rspWord & 16'h3FFF);
    eCmdV = 0; eAngV = 0; eMagV = 0; eGainV = 0; eDiagV = 0; eErrV = 0;
    if (!w && !engBusy && ((s % 2 == 1 && s < 8) || tick)) begin
      eCmdV = 1; eCmd = 'h4000 | addrFor(s); mWait = 1;
    end
    if (rspValid && w) begin
      mWait = 0;
      if (!rspCrcOk || rspWord[14]) begin
        if (eCnt < ECAP) eCnt++;
        mState = 8;
      end else begin
        case (s)
          0, 2, 4, 6: begin eAng = d; eAngV = 1; mState = s + 1; end
          1: begin eMag = d; eMagV = 1; mState = 2; end
          3: begin eGain = d & 'hFF; eGainV = 1; mState = 4; end
          5: begin
            eDiag = {d[4], d[3], d[2], d[10]}; eDiagV = 1; mState = 6;
          end
          7: begin eErrFl = {d[1], d[6], d[7]}; eErrV = 1; mState = 0; end
          default: mState = 7;
        endcase
      end
    end
  endtask

  // Sensor and engine state
  int angleSeq = 100, diagToggle = 0, replyIdx = 0, busyCnt = 0;
  int prevAddr = 'h3FFF, pendAddr = 'h3FFF;
  int nMag = 0, nGain = 0, nDiag = 0, nErr = 0, nAng = 0;
  logic [15:0] issued[$];

  function automatic logic [15:0] sensorWord(input int a);
    case (a)
      'h3FFF: return 16'((angleSeq & 'h3FFF) | ((angleSeq & 1) << 15));
      'h3FFD: return 16'h9A2B;
      'h3FF9: return 16'h2D5C;
      'h3FF5: return (diagToggle % 2 == 0) ? 16'h041C : 16'h0000;
      default: return (diagToggle % 2 == 0) ? 16'h00C2 : 16'h0080;
    endcase
  endfunction

  task automatic compareAll();
    chk(cmdValid == eCmdV, "R9 cmdValid", int'(cmdValid), int'(eCmdV));
    if (eCmdV) chk(cmdWord == 16'(eCmd), "R2 R3 cmdWord", int'(cmdWord), eCmd);
    chk(angleValid == eAngV, "R4 angleValid", int'(angleValid), int'(eAngV));
    chk(angle == 14'(eAng), "R4 R10 angle", int'(angle), eAng);
    chk(magValid == eMagV, "R5 magValid", int'(magValid), int'(eMagV));
    chk(magnitude == 14'(eMag), "R5 R8 magnitude", int'(magnitude), eMag);
    chk(gainValid == eGainV, "R5 gainValid", int'(gainValid), int'(eGainV));
    chk(gain == 8'(eGain), "R5 gain", int'(gain), eGain);
    chk(diagValid == eDiagV, "R5 diagValid", int'(diagValid), int'(eDiagV));
    chk({fieldHigh, fieldLow, cordicOvf, hallFault} == 4'(eDiag), "R5 diag bits",
        int'({fieldHigh, fieldLow, cordicOvf, hallFault}), eDiag);
    chk(errFlagsValid == eErrV, "R5 R7 errFlagsValid", int'(errFlagsValid), int'(eErrV));
    chk({halfMag, crcFlag, wdtFlag} == 3'(eErrFl), "R7 error flag bits",
        int'({halfMag, crcFlag, wdtFlag}), eErrFl);
    chk(errCount == ERRW'(eCnt), "R6 errCount", int'(errCount), eCnt);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state at release
    chk(cmdValid == 0 && angleValid == 0 && magValid == 0 && errFlagsValid == 0,
        "R1 valids after reset", int'({cmdValid, angleValid, magValid, errFlagsValid}), 0);
    chk(errCount == 0 && angle == 0 && magnitude == 0 && gain == 0,
        "R1 fields after reset", int'(errCount) + int'(angle) + int'(magnitude) + int'(gain), 0);
    for (int cyc = 0; cyc < 2400; cyc++) begin
      if (cyc != 0) @(negedge clk);
      compareAll();
      if (angleValid) nAng++;
      if (magValid) nMag++;
      if (gainValid) nGain++;
      if (diagValid) nDiag++;
      if (errFlagsValid) nErr++;
      if (cmdValid) begin
        issued.push_back(cmdWord);
        pendAddr = int'(cmdWord[13:0]);
        busyCnt = LAT;
      end
      rspValid = 1'b0;
      if (busyCnt > 0) begin
        busyCnt--;
        if (busyCnt == 0) begin
          replyIdx++;
          rspValid = 1'b1;
          rspWord = sensorWord(prevAddr);
          if (prevAddr == 'h3FFF) angleSeq += 1237;
          if (prevAddr == 'h3FF5 || prevAddr == 'h0001) diagToggle++;
          rspCrcOk = !(replyIdx == 9 || (replyIdx >= 40 && replyIdx < 52));
          if (replyIdx == 17 || replyIdx == 26) rspWord[14] = 1'b1;
          prevAddr = pendAddr;
        end
      end
      engBusy = (busyCnt > 0);
      tick = (cyc % 11 == 0) || (cyc % 17 == 5);
      modelStep();
    end
    // R3: command order from reset
    begin
      int exp[8] = '{'h7FFD, 'h7FFF, 'h7FF9, 'h7FFF, 'h7FF5, 'h7FFF, 'h4001, 'h7FFF};
      for (int i = 0; i < 8; i++)
        chk(issued.size() > i && int'(issued[i]) == exp[i], "R3 order",
            issued.size() > i ? int'(issued[i]) : -1, exp[i]);
    end
    // R6: saturation reached after the burst
    chk(errCount == ERRW'(ECAP), "R6 saturation", int'(errCount), ECAP);
    // R8: magnitude without warning bit
    chk(magnitude == 14'h1A2B, "R8 warning ignored", int'(magnitude), 'h1A2B);
    // R5 R7: every field group decoded at least once
    chk(nAng > 0 && nMag > 0 && nGain > 0 && nDiag > 0 && nErr > 0, "R5 coverage",
        nAng * nMag * nGain * nDiag * nErr, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule